// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a down-counter, sixteen bits wide by default, with two operating modes. A CPU writes a reload value a byte at a time into an upper and a lower byte register. The counter runs only on cycles where a selected clock-enable source is high. The source is picked by a select field from a set of enable inputs. On every enabled cycle the count drops by one. A terminal count event fires on the enabled cycle in which the count stands at one.

In timer mode the counter never stops. At each terminal count it reloads itself and toggles a square-wave output, so the block acts as a programmable divider. The square wave can drive an output pin and can also serve as a clock for a baud-rate selector elsewhere. In counter mode software gates the counter with start and stop commands, which gives a one-shot timeout. After the terminal count the counter keeps wrapping downward until it is stopped. Once stopped, its value is readable. Both modes raise a sticky interrupt flag at terminal count, and a stop command clears it.

Top module: `prog_down_timer`

## Requirements
- R1: After reset the count is 0, the counter is stopped, `sq_out` is 0, `tc_irq` is 0, and `rd_count` reads 0.
- R2: The reload value is {upper byte, lower byte}. `pre_wr` bit 0 writes `pre_data` into the lower byte and bit 1 writes it into the upper byte. A byte written in the same cycle as a start command is used by that start.
- R3: The count changes on a counting cycle only if `clk_en_src[clk_sel]` is 1. Enable inputs that are not selected have no effect.
- R4: In timer mode (`mode_timer`=1) the counter runs without a start. On an enabled cycle with count 1 it reloads the current reload value and toggles `sq_out`, so the toggle period is P enabled cycles. A start command in timer mode reloads the count.
- R5: In counter mode (`mode_timer`=0) a start command loads the reload value and sets the counter running. The count then drops by one on every enabled cycle.
- R6: A stop command leaves the count unchanged in its cycle and halts a counter-mode count until the next start. Stop wins over a start given in the same cycle. `rd_count` shows the count while stopped in counter mode and reads 0 otherwise.
- R7: `tc_irq` goes to 1 on the terminal count in either mode and stays at 1 until a stop command clears it.
- R8: In counter mode the count keeps decrementing after the terminal count, wrapping from 0 to 0xFFFF, until stopped.
- R9: A reload value of 0 counts 65536 enabled cycles to the terminal count.
- R10: Writing the reload value while counting does not alter the present count. The new value applies at the next load or reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_wr | input | 2 | Byte write strobes: bit 0 lower, bit 1 upper |
| pre_data | input | 8 | Byte written into the reload register |
| mode_timer | input | 1 | 1 = free-running timer, 0 = software-gated counter |
| cmd_start | input | 1 | Load and start command |
| cmd_stop | input | 1 | Stop command; clears the interrupt flag |
| clk_sel | input | 2 | Selects which enable input drives counting |
| clk_en_src | input | 4 | Candidate clock-enable inputs |
| rd_count | output | 16 | Current count while stopped in counter mode, else 0 |
| sq_out | output | 1 | Square-wave output of timer mode |
| tc_irq | output | 1 | Sticky terminal-count interrupt flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit count and four enable sources. With these values a zero reload, and so the full 65536-cycle wrap, fits in the run. The four enable inputs are driven as always-on, alternating, never, and every-third-cycle. This lets the bench compare gated counting, a held count and a mixed cadence against a behavioural model on every clock. Directed steps cover the same-cycle start-and-write case, the start-and-stop collision, the wrap past zero, and the timer divide ratio.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    typedef enum logic {
        PDT_COUNTER = 1'b0,
        PDT_TIMER   = 1'b1
    } pdt_mode_e;
endpackage

// File: rtl/pdt_src_mux.sv
module pdt_src_mux #(
    parameter  int NSRC  = 4,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  src_en,
    input  logic [SEL_W-1:0] src_sel,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    // One gate per source; an out-of-range select yields no tick (R3)
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src_en[g] && (src_sel == SEL_W'(g));
    end

    assign tick = |hit;
endmodule

// File: rtl/pdt_preload.sv
module pdt_preload #(
    parameter  int BYTE_W = 8,
    parameter  int NBYTES = 2,
    localparam int TOT_W  = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [TOT_W-1:0]  val_next
);
    logic [NBYTES-1:0][BYTE_W-1:0] lane_d, lane_q;

    // Lane 0 is the lower byte, the highest lane the upper byte (R2)
    always_comb begin
        lane_d = lane_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (wr[i]) begin
                lane_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    // Next value, so a write in a start cycle is seen by that start
    assign val_next = lane_d;
endmodule

// File: rtl/pdt_core.sv
module pdt_core #(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic                stop,
    input  pdt_pkg::pdt_mode_e  mode,
    input  logic [CNT_W-1:0]    reload,
    output logic [CNT_W-1:0]    count,
    output logic                running,
    output logic                sq,
    output logic                irq
);
    import pdt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             sq;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     is_timer;
    logic     active;
    logic     at_tc;

    assign is_timer = (mode == PDT_TIMER);
    assign active   = is_timer || st_q.run;
    assign at_tc    = (st_q.count == ONE);

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d.run = 1'b0;
            st_d.irq = 1'b0;
        end else if (start) begin
            st_d.count = reload;
            st_d.run   = 1'b1;
        end else if (active && tick) begin
            if (at_tc) begin
                st_d.irq = 1'b1;
                if (is_timer) begin
                    st_d.count = reload;
                    st_d.sq    = ~st_q.sq;
                end else begin
                    st_d.count = st_q.count - ONE;
                end
            end else begin
                st_d.count = st_q.count - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.count;
    assign running = st_q.run;
    assign sq      = st_q.sq;
    assign irq     = st_q.irq;

    // A stop leaves the flag low in the following cycle
    assert_stop_clears_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !irq);

    // Terminal count raises the flag
    assert_tc_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_tc && active && !start && !stop) |=> irq);

    // Stop cycles and halted counter mode hold the count
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop || (!is_timer && !running && !start)) |=> $stable(count));

    // No enable, no movement
    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(count));

    // Running counter mode steps down by one, wrapping past zero (R8)
    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_timer && running && tick && !start && !stop)
        |=> (count == $past(count) - ONE));

    // The square wave moves only on a timer-mode terminal count
    assert_sq_on_tc_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_timer && tick && at_tc && !start && !stop) |=> $stable(sq));
endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer #(
    parameter  int BYTE_W = 8,
    parameter  int NSRC   = 4,
    localparam int NBYTES = 2,
    localparam int CNT_W  = BYTE_W * NBYTES,
    localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] pre_wr,
    input  logic [BYTE_W-1:0] pre_data,
    input  logic              mode_timer,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [NSRC-1:0]   clk_en_src,
    output logic [CNT_W-1:0]  rd_count,
    output logic              sq_out,
    output logic              tc_irq
);
    import pdt_pkg::*;

    logic             tick;
    logic [CNT_W-1:0] reload_nx;
    logic [CNT_W-1:0] cnt;
    logic             run;
    pdt_mode_e        mode;

    assign mode = pdt_mode_e'(mode_timer);

    pdt_src_mux #(.NSRC(NSRC)) u_src (
        .src_en  (clk_en_src),
        .src_sel (clk_sel),
        .tick    (tick)
    );

    pdt_preload #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (pre_wr),
        .wdata    (pre_data),
        .val_next (reload_nx)
    );

    pdt_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (cmd_start),
        .stop    (cmd_stop),
        .mode    (mode),
        .reload  (reload_nx),
        .count   (cnt),
        .running (run),
        .sq      (sq_out),
        .irq     (tc_irq)
    );

    // Count is visible only while a counter-mode count is halted (R6)
    always_comb begin
        rd_count = '0;
        if (mode == PDT_COUNTER && !run) begin
            rd_count = cnt;
        end
    end
endmodule

// File: tb/prog_down_timer_tb.sv
module prog_down_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pre_wr = '0;
    logic [7:0]  pre_data = '0;
    logic        mode_timer = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic [1:0]  clk_sel = '0;
    logic [3:0]  clk_en_src;
    logic [15:0] rd_count;
    logic        sq_out;
    logic        tc_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;

    always #2 clk = ~clk;

    // Sources: 0 always, 1 alternating, 2 never, 3 every third cycle
    always @(negedge clk) cyc_n <= cyc_n + 1;
    assign clk_en_src = {(cyc_n % 3 == 0), 1'b0, cyc_n[0], 1'b1};

    prog_down_timer u_dut (
        .clk(clk), .rst_n(rst_n), .pre_wr(pre_wr), .pre_data(pre_data),
        .mode_timer(mode_timer), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .clk_sel(clk_sel), .clk_en_src(clk_en_src),
        .rd_count(rd_count), .sq_out(sq_out), .tc_irq(tc_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_pre, m_cnt, m_run, m_sq, m_irq;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_run = 0; m_sq = 0; m_irq = 0;
        end else begin
            if (pre_wr[0]) m_pre = (m_pre & 32'hFF00) | int'(pre_data);
            if (pre_wr[1]) m_pre = (m_pre & 32'h00FF) | (int'(pre_data) << 8);
            if (cmd_stop) begin
                m_run = 0; m_irq = 0;
            end else if (cmd_start) begin
                m_cnt = m_pre; m_run = 1;
            end else if ((mode_timer || m_run != 0) && clk_en_src[clk_sel]) begin
                if (m_cnt == 1) begin
                    m_irq = 1;
                    if (mode_timer) begin
                        m_cnt = m_pre; m_sq = 1 - m_sq;
                    end else begin
                        m_cnt = 0;
                    end
                end else begin
                    m_cnt = (m_cnt + 65535) & 32'hFFFF;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 model readout", rd_count, (!mode_timer && m_run == 0) ? m_cnt : 0);
            chk("R4 model square", sq_out, m_sq);
            chk("R7 model flag", tc_irq, m_irq);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_pre(input logic [1:0] lanes, input logic [7:0] d);
        pre_wr = lanes; pre_data = d;
        wait_n(1);
        pre_wr = '0;
    endtask

    task automatic do_start();
        cmd_start = 1'b1; wait_n(1); cmd_start = 1'b0;
    endtask

    task automatic do_stop();
        cmd_stop = 1'b1; wait_n(1); cmd_stop = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #640000;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        int toggles;
        logic last_sq;
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_count", rd_count, 0);
        chk("R1 sq_out", sq_out, 0);
        chk("R1 tc_irq", tc_irq, 0);

        // R2 byte order, same-cycle write seen by start
        wr_pre(2'b10, 8'h12);
        pre_wr = 2'b01; pre_data = 8'h34; cmd_start = 1'b1;
        wait_n(1);
        pre_wr = '0; cmd_start = 1'b0;
        do_stop();
        chk("R2 concatenated reload", rd_count, 16'h1234);

        // R3 unselected/never source holds count
        clk_sel = 2'd2;
        do_start();
        wait_n(10);
        do_stop();
        chk("R3 never source holds", rd_count, 16'h1234);
        // R3 alternating source: 5 ticks in 10 cycles
        clk_sel = 2'd1;
        do_start();
        wait_n(10);
        do_stop();
        chk("R3 alternating source", rd_count, 16'h122F);

        // R5 start loads and steps by one
        clk_sel = 2'd0;
        wr_pre(2'b11, 8'h00);
        wr_pre(2'b01, 8'h02);
        do_start();
        wait_n(1);
        do_stop();
        chk("R5 one step", rd_count, 16'h0001);
        chk("R5 no flag yet", tc_irq, 0);

        // R8 wrap past zero, R7 flag, R6 zero readout while running
        do_start();
        wait_n(4);
        chk("R7 flag at terminal", tc_irq, 1);
        chk("R6 readout zero while running", rd_count, 0);
        do_stop();
        chk("R7 stop clears flag", tc_irq, 0);
        chk("R8 wrap through zero", rd_count, 16'hFFFE);

        // R10 write during run does not disturb count
        wr_pre(2'b01, 8'h10);
        do_start();
        wr_pre(2'b01, 8'h80);
        wait_n(2);
        do_stop();
        chk("R10 count undisturbed", rd_count, 16'h000D);
        do_start();
        do_stop();
        chk("R10 new value at next load", rd_count, 16'h0080);

        // R4 timer divider: reload 3, 60 enabled cycles -> 20 toggles
        wr_pre(2'b01, 8'h03);
        mode_timer = 1'b1;
        do_start();
        toggles = 0;
        last_sq = sq_out;
        for (int i = 0; i < 60; i++) begin
            wait_n(1);
            if (sq_out !== last_sq) toggles++;
            last_sq = sq_out;
        end
        chk("R4 toggle count", toggles, 20);
        chk("R7 flag in timer mode", tc_irq, 1);
        chk("R6 readout zero in timer mode", rd_count, 0);
        do_stop();
        chk("R7 stop clears flag in timer mode", tc_irq, 0);
        mode_timer = 1'b0;

        // R9 zero reload means 65536 cycles
        wr_pre(2'b11, 8'h00);
        do_start();
        wait_n(65535);
        chk("R9 no flag before 65536", tc_irq, 0);
        wait_n(1);
        chk("R9 flag at 65536", tc_irq, 1);

        // R6 stop wins over start in the same cycle
        wait_n(2);
        cmd_start = 1'b1; cmd_stop = 1'b1;
        wait_n(1);
        cmd_start = 1'b0; cmd_stop = 1'b0;
        chk("R6 stop wins count", rd_count, 16'hFFFE);
        chk("R6 stop wins flag", tc_irq, 0);
        wait_n(5);
        chk("R6 halted stays", rd_count, 16'hFFFE);

        finish_run();
    end
endmodule